// File: doc/BRIEF.md
# Serial-Bus Wiper Controller with Retained Settings

This block is a two-wire serial-bus slave that owns the 6-bit code of a 64-step variable resistor. It samples the bus clock and data lines with its own system clock, so no logic runs on the bus clock. Its 7-bit bus address has five fixed upper bits and two low bits taken from strap pins. After the address, each write carries an instruction byte. The top three bits of that byte choose an operation and the low five bits give a storage index. The operations are: set the wiper, write a retained-storage entry, toggle a software write lock, copy the wiper into storage, and copy storage back into the wiper.

Retained storage is modelled as a register array of 32 bytes. The top two entries are a fixed, read-only tolerance record: a sign and integer byte, followed by a binary-fraction byte. Reads follow a pointer that the last instruction leaves behind. When that pointer selects storage, it advances each time the bus master acknowledges a byte. This lets the two tolerance bytes come out in a single burst.

The bus data line is open-drain. The block therefore gives out an enable that, when high, pulls the line low.

Top module: `digipot_i2c_ctrl`

## Requirements
- R1: After reset the wiper code is 32 (mid-scale), the write lock is off, the data-line pull-down is released, and a read before any instruction returns 8'h20.
- R2: The device address is {01011, strap[1], strap[0]}. The strap pins are captured on the first clock after reset, and later changes to them have no effect. An address that does not match gets no acknowledge, and the rest of that transfer has no effect.
- R3: The block pulls the data line low during the ninth clock of a matching address byte, of every instruction byte and of every write data byte. It changes the pull-down only while the bus clock is low.
- R4: Instruction code 001 makes each following data byte set the wiper to that byte's bits 5:0, with bits 7:6 ignored. This repeats for every data byte until STOP.
- R5: Instruction code 011 takes data bit 0 as the new write-lock state (1 = locked, shown on `wp_o`). Nothing is stored.
- R6: Instruction code 010 writes each data byte into the storage entry named by the instruction's low five bits. Entries 30 and 31 are read-only and hold the tolerance bytes (defaults 8'h1C and 8'h0F).
- R7: While the write lock is on, storage writes and wiper saves leave storage unchanged.
- R8: Instruction code 101 stores {2'b00, wiper} into entry 0. Code 100 loads bits 5:0 of entry 0 into the wiper. Neither needs a data byte.
- R9: A read (address with R/W = 1, bit 0 of the address byte) returns bits MSB first from the pointer. Instruction 001 points at the wiper, returned as {2'b00, wiper}. Instruction 010 points at the given entry. A read that starts directly with the address byte reuses the current pointer.
- R10: When the pointer is on storage, a master acknowledge advances it by one (so 30 moves to 31). A master not-acknowledge leaves it where it is.
- R11: Instruction codes 000, 110 and 111 are acknowledged and have no effect, and the data bytes that follow them are acknowledged and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Address strap pins, low two address bits |
| sda_oe_o | output | 1 | High pulls the data line low |
| wiper_o | output | 6 | Current wiper code |
| wp_o | output | 1 | Software write lock state |

## Verification
The bench targets the data-byte bits 7:6 in a wiper write. A design that used them would load a code above 63 or a wrong code. It checks that a protected save really leaves entry 0 alone, using a restore afterwards. A design that gated only explicit storage writes would restore the newer wiper value. A write to entry 30 must still read back the factory byte. The two-byte tolerance burst must advance on the acknowledge but not on the final not-acknowledge: an off-by-one pointer shows as the wrong second byte, or as the wrong byte on a direct re-read. Changing the straps after reset, and using an unknown instruction code, show whether an address is re-sampled or a stray code is acted on.

// File: rtl/digipot_pkg.sv
package digipot_pkg;

    localparam int WIPER_W  = 6;
    localparam int DATA_W   = 8;
    localparam int NV_AW    = 5;
    localparam int NV_DEPTH = 1 << NV_AW;
    localparam int RO_COUNT = 2;

    localparam logic [4:0]         DEV_ADDR_HI = 5'b01011;
    localparam logic [WIPER_W-1:0] WIPER_MID   = WIPER_W'(1 << (WIPER_W - 1));

    typedef enum logic [2:0] {
        OP_NOP     = 3'b000,
        OP_WIPER   = 3'b001,
        OP_NV      = 3'b010,
        OP_WP      = 3'b011,
        OP_RESTORE = 3'b100,
        OP_SAVE    = 3'b101
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INSTR,
        PH_DATA
    } ph_e;

    typedef struct packed {
        logic             is_nv;
        logic [NV_AW-1:0] addr;
    } ptr_t;

    function automatic op_e decode_op(input logic [2:0] code);
        case (code)
            3'b001:  return OP_WIPER;
            3'b010:  return OP_NV;
            3'b011:  return OP_WP;
            3'b100:  return OP_RESTORE;
            3'b101:  return OP_SAVE;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pad_wiper(input logic [WIPER_W-1:0] w);
        return {{(DATA_W - WIPER_W){1'b0}}, w};
    endfunction

endpackage

// File: rtl/digipot_line_sampler.sv
module digipot_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // STAGES synchronizer flops plus one history flop per line
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/digipot_nv_store.sv
module digipot_nv_store
    import digipot_pkg::*;
#(
    parameter logic [DATA_W-1:0] TOL_HI = 8'h1C,
    parameter logic [DATA_W-1:0] TOL_LO = 8'h0F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic               lock_i,
    input  logic [NV_AW-1:0]   waddr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NV_AW-1:0]   raddr_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [WIPER_W-1:0] word0_o
);
    localparam int RW_DEPTH = NV_DEPTH - RO_COUNT;
    localparam logic [NV_AW-1:0] RO_HI_ADDR = NV_AW'(NV_DEPTH - 2);
    localparam logic [NV_AW-1:0] RO_LO_ADDR = NV_AW'(NV_DEPTH - 1);

    logic [DATA_W-1:0] mem [RW_DEPTH];
    logic              wr_ok;

    // Lock and read-only region both veto the store
    assign wr_ok = we_i && !lock_i && (waddr_i < NV_AW'(RW_DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RW_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        if (raddr_i == RO_HI_ADDR) begin
            rdata_o = TOL_HI;
        end else if (raddr_i == RO_LO_ADDR) begin
            rdata_o = TOL_LO;
        end else begin
            rdata_o = mem[raddr_i];
        end
    end

    assign word0_o = mem[0][WIPER_W-1:0];

endmodule

// File: rtl/digipot_i2c_ctrl.sv
module digipot_i2c_ctrl
    import digipot_pkg::*;
#(
    parameter logic [DATA_W-1:0] TOL_SIGN_INT = 8'h1C,
    parameter logic [DATA_W-1:0] TOL_FRAC     = 8'h0F,
    parameter int                SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [1:0]         strap_i,
    output logic               sda_oe_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic               wp_o
);
    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    digipot_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    st_e                st;
    ph_e                ph;
    op_e                op_q;
    ptr_t               ptr;
    logic [3:0]         bitcnt;
    logic [DATA_W-1:0]  shreg;
    logic [DATA_W-1:0]  txreg;
    logic [WIPER_W-1:0] wiper_q;
    logic               wp_q;
    logic               sda_oe_q;
    logic               rd_q;
    logic               mack_q;
    logic [1:0]         strap_q;
    logic               strap_taken;

    logic               nv_we;
    logic [NV_AW-1:0]   nv_waddr;
    logic [DATA_W-1:0]  nv_wdata;
    logic [NV_AW-1:0]   nv_raddr;
    logic [DATA_W-1:0]  nv_rdata;
    logic [WIPER_W-1:0] nv_word0;

    logic               byte_done;
    op_e                instr_op;
    logic [DATA_W-1:0]  tx_byte;
    logic [6:0]         own_addr;

    assign byte_done = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
    assign instr_op  = decode_op(shreg[7:5]);
    assign own_addr  = {DEV_ADDR_HI, strap_q};
    assign nv_raddr  = ptr.addr;
    assign tx_byte   = ptr.is_nv ? nv_rdata : pad_wiper(wiper_q);

    always_comb begin
        nv_we    = 1'b0;
        nv_waddr = '0;
        nv_wdata = '0;
        if (byte_done && ph == PH_INSTR && instr_op == OP_SAVE) begin
            nv_we    = 1'b1;
            nv_wdata = pad_wiper(wiper_q);
        end else if (byte_done && ph == PH_DATA && op_q == OP_NV) begin
            nv_we    = 1'b1;
            nv_waddr = ptr.addr;
            nv_wdata = shreg;
        end
    end

    digipot_nv_store #(.TOL_HI(TOL_SIGN_INT), .TOL_LO(TOL_FRAC)) u_nv (
        .clk     (clk),
        .rst     (rst),
        .we_i    (nv_we),
        .lock_i  (wp_q),
        .waddr_i (nv_waddr),
        .wdata_i (nv_wdata),
        .raddr_i (nv_raddr),
        .rdata_o (nv_rdata),
        .word0_o (nv_word0)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ph          <= PH_ADDR;
            op_q        <= OP_NOP;
            ptr         <= '{is_nv: 1'b0, addr: '0};
            bitcnt      <= '0;
            shreg       <= '0;
            txreg       <= '0;
            wiper_q     <= WIPER_MID;
            wp_q        <= 1'b0;
            sda_oe_q    <= 1'b0;
            rd_q        <= 1'b0;
            mack_q      <= 1'b0;
            strap_q     <= '0;
            strap_taken <= 1'b0;
        end else begin
            if (!strap_taken) begin
                strap_q     <= strap_i;
                strap_taken <= 1'b1;
            end
            if (bus_start) begin
                st       <= ST_RX;
                ph       <= PH_ADDR;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
            end else if (bus_stop) begin
                st       <= ST_IDLE;
                sda_oe_q <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            case (ph)
                                PH_ADDR: begin
                                    if (shreg[7:1] == own_addr) begin
                                        sda_oe_q <= 1'b1;
                                        rd_q     <= shreg[0];
                                        st       <= ST_RX_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_INSTR: begin
                                    sda_oe_q <= 1'b1;
                                    st       <= ST_RX_ACK;
                                    op_q     <= instr_op;
                                    case (instr_op)
                                        OP_WIPER:   ptr <= '{is_nv: 1'b0, addr: shreg[NV_AW-1:0]};
                                        OP_NV:      ptr <= '{is_nv: 1'b1, addr: shreg[NV_AW-1:0]};
                                        OP_RESTORE: wiper_q <= nv_word0;
                                        default:    ;
                                    endcase
                                end
                                default: begin
                                    sda_oe_q <= 1'b1;
                                    st       <= ST_RX_ACK;
                                    case (op_q)
                                        OP_WIPER: wiper_q <= shreg[WIPER_W-1:0];
                                        OP_WP:    wp_q    <= shreg[0];
                                        default:  ;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (ph == PH_ADDR && rd_q) begin
                                txreg    <= tx_byte;
                                sda_oe_q <= ~tx_byte[DATA_W-1];
                                st       <= ST_TX;
                            end else begin
                                sda_oe_q <= 1'b0;
                                st       <= ST_RX;
                                ph       <= (ph == PH_ADDR) ? PH_INSTR : PH_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe_q <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                txreg    <= {txreg[DATA_W-2:0], 1'b0};
                                sda_oe_q <= ~txreg[DATA_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                            if (!sda_s && ptr.is_nv) begin
                                ptr.addr <= ptr.addr + NV_AW'(1);
                            end
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                txreg    <= tx_byte;
                                sda_oe_q <= ~tx_byte[DATA_W-1];
                                bitcnt   <= '0;
                                st       <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = sda_oe_q;
    assign wiper_o  = wiper_q;
    assign wp_o     = wp_q;

endmodule

// File: rtl/digipot_chk.sv
module digipot_chk
    import digipot_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_oe_o,
    input logic [WIPER_W-1:0] wiper_o,
    input logic               wp_o,
    input logic [1:0]         strap_q,
    input logic               strap_taken,
    input logic               nv_we,
    input logic [NV_AW-1:0]   nv_waddr,
    input logic [NV_AW-1:0]   nv_raddr,
    input logic [DATA_W-1:0]  nv_rdata
);
    localparam logic [NV_AW-1:0] RO_FIRST = NV_AW'(NV_DEPTH - RO_COUNT);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper_o == WIPER_MID && !wp_o && !sda_oe_o)); // R1

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (strap_taken && $past(strap_taken)) |-> $stable(strap_q)); // R2

    AST_PULLDOWN_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i); // R3

    AST_WIPER_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper_o) |-> !scl_i); // R4

    AST_TOL_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (nv_raddr >= RO_FIRST && $past(nv_raddr) == nv_raddr) |-> $stable(nv_rdata)); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wp_o && nv_we && nv_raddr == nv_waddr) |=> $stable(nv_rdata)); // R7

endmodule

bind digipot_i2c_ctrl digipot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .wiper_o     (wiper_o),
    .wp_o        (wp_o),
    .strap_q     (strap_q),
    .strap_taken (strap_taken),
    .nv_we       (nv_we),
    .nv_waddr    (nv_waddr),
    .nv_raddr    (nv_raddr),
    .nv_rdata    (nv_rdata)
);

// File: tb/sim_digipot_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_digipot_i2c_ctrl;
    localparam int Q = 10;
    localparam logic [7:0] AW = 8'h5C;  // 01011 10 0
    localparam logic [7:0] AR = 8'h5D;  // 01011 10 1

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic [5:0] wiper;
    logic       wp;
    logic       sda_bus;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    digipot_i2c_ctrl u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .wiper_o  (wiper),
        .wp_o     (wp)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic wb(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait();
            m_scl = 1'b1; qwait(); qwait();
            m_scl = 1'b0; qwait();
        end
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        ack = ~sda_bus; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic rb(input logic give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; qwait();
            m_scl = 1'b1; qwait();
            b = {b[6:0], sda_bus}; qwait();
            m_scl = 1'b0; qwait();
        end
        m_sda = ~give_ack; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
        m_sda = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] instr, input logic [7:0] data, input logic with_data);
        logic a;
        bus_start();
        wb(AW, a);    chk("R3 addr ack", a, 1);
        wb(instr, a); chk("R3 instr ack", a, 1);
        if (with_data) begin
            wb(data, a); chk("R3 data ack", a, 1);
        end
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] instr, output logic [7:0] b);
        logic a;
        bus_start();
        wb(AW, a);
        wb(instr, a);
        bus_start();
        wb(AR, a); chk("R9 read addr ack", a, 1);
        rb(1'b0, b);
        bus_stop();
    endtask

    task automatic read_direct(output logic [7:0] b);
        logic a;
        bus_start();
        wb(AR, a);
        rb(1'b0, b);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 wiper mid", wiper, 32);
        chk("R1 lock off", wp, 0);
        chk("R1 pulldown off", sda_oe, 0);
        read_direct(b);
        chk("R1 first read", b, 8'h20);
    endtask

    task automatic t_wiper_burst();
        logic a;
        bus_start();
        wb(AW, a); wb(8'h20, a);
        wb(8'hC5, a); chk("R4 bits 7:6 ignored", wiper, 6'h05);
        wb(8'h3F, a); chk("R4 repeat top", wiper, 63);
        wb(8'h00, a); chk("R4 repeat zero", wiper, 0);
        bus_stop();
    endtask

    task automatic t_address();
        logic a;
        strap = 2'b01;
        bus_start();
        wb(8'h5A, a); chk("R2 mismatch no ack", a, 0);
        wb(8'h20, a);
        wb(8'h15, a);
        bus_stop();
        chk("R2 mismatch no effect", wiper, 0);
        cmd(8'h20, 8'h2A, 1'b1);
        chk("R2 strap frozen", wiper, 6'h2A);
    endtask

    task automatic t_read_wiper();
        logic [7:0] b;
        read_at(8'h20, b); chk("R9 wiper read", b, 8'h2A);
        read_direct(b);    chk("R9 direct reread", b, 8'h2A);
    endtask

    task automatic t_nv();
        logic [7:0] b;
        cmd(8'h45, 8'hA7, 1'b1);
        read_at(8'h45, b); chk("R6 entry 5", b, 8'hA7);
        cmd(8'h5E, 8'h55, 1'b1);
        read_at(8'h5E, b); chk("R6 entry 30 read-only", b, 8'h1C);
    endtask

    task automatic t_tolerance();
        logic a;
        logic [7:0] b;
        bus_start();
        wb(AW, a); wb(8'h5E, a);
        bus_start();
        wb(AR, a);
        rb(1'b1, b); chk("R10 tol first", b, 8'h1C);
        rb(1'b0, b); chk("R10 tol second", b, 8'h0F);
        bus_stop();
        read_direct(b); chk("R10 advanced on ack", b, 8'h0F);
        read_direct(b); chk("R10 nack holds", b, 8'h0F);
    endtask

    task automatic t_save_restore();
        logic [7:0] b;
        cmd(8'h20, 8'h11, 1'b1);
        cmd(8'hA0, 8'h00, 1'b0);
        cmd(8'h20, 8'h30, 1'b1);
        chk("R8 before restore", wiper, 6'h30);
        cmd(8'h80, 8'h00, 1'b0);
        chk("R8 restore", wiper, 6'h11);
        read_at(8'h40, b); chk("R8 entry 0 saved", b, 8'h11);
    endtask

    task automatic t_lock();
        logic [7:0] b;
        cmd(8'h60, 8'h01, 1'b1);
        chk("R5 lock on", wp, 1);
        chk("R5 wiper untouched", wiper, 6'h11);
        cmd(8'h45, 8'h3C, 1'b1);
        read_at(8'h45, b); chk("R7 locked write", b, 8'hA7);
        cmd(8'h20, 8'h22, 1'b1);
        cmd(8'hA0, 8'h00, 1'b0);
        cmd(8'h80, 8'h00, 1'b0);
        chk("R7 locked save", wiper, 6'h11);
        cmd(8'h60, 8'hFE, 1'b1);
        chk("R5 lock off by bit0", wp, 0);
        cmd(8'h45, 8'h3C, 1'b1);
        read_at(8'h45, b); chk("R6 unlocked write", b, 8'h3C);
    endtask

    task automatic t_nop();
        cmd(8'hE0, 8'h07, 1'b1);
        chk("R11 code 111", wiper, 6'h11);
        cmd(8'hC0, 8'h09, 1'b1);
        chk("R11 code 110", wiper, 6'h11);
        cmd(8'h00, 8'h3A, 1'b1);
        chk("R11 code 000", wiper, 6'h11);
        chk("R11 lock unchanged", wp, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        t_reset();
        t_wiper_burst();
        t_address();
        t_read_wiper();
        t_nv();
        t_tolerance();
        t_save_restore();
        t_lock();
        t_nop();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule